// File: doc/BRIEF.md
# Restartable Masked Gather Engine

This block carries out a vector gather as a series of single-element memory reads. A lane mask chooses which lanes take part. Each selected lane reads from a base address plus its own index scaled by a fixed element size. Lanes are visited from the lowest selected lane upward, and only one read is in flight at any time. When a read returns good data, the data goes into that lane of the result vector and the lane's mask bit is cleared.

The operation can stop before all lanes are done, for two reasons. The first is a pending interrupt, which the block only looks at between elements. The second is a fault reported on a read. In both cases the lanes already finished keep their data, and the mask keeps only the lanes still outstanding. The caller can then pass `maskOut` and `dataOut` back in as a new start, and the block carries on with only the remaining lanes. After each start the block always performs at least one element, so a gather that keeps being interrupted still moves forward.

Top module: `gather_engine`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `doneValid` and `memReqValid` are all low.
- R2: Lanes are read one at a time, lowest selected lane first. Each read address is `startBase` plus the unsigned index of that lane times ELEM_BYTES (4 by default). Lane i's index sits at bits [i*IDX_W +: IDX_W] of `startIdx`.
- R3: Only one read is outstanding at a time. After a request is accepted, no new request is raised until its response has come back.
- R4: A good response writes its data into that lane of `dataOut` and clears the lane's bit in `maskOut`. Lanes that were not selected keep the value loaded from `startData`.
- R5: A response with `memRspFault` set ends the operation with `doneStatus` = 2. `faultLane` and `faultAddr` hold the lane and its address, that lane's mask bit stays set and its data is left unchanged, and lanes finished earlier keep their results.
- R6: `irqPending` is checked only between elements. When it is set at that point and lanes remain, the operation ends with `doneStatus` = 1 and no further read. The first element after each start is always performed, whatever `irqPending` says.
- R7: When the mask is all zero at an element boundary, the operation ends with `doneStatus` = 0. This takes priority over an interrupt. A start with a zero mask completes without making any read.
- R8: Restarting with the returned mask and data reads only the lanes still set. Over a whole gather, the number of reads equals the number of selected lanes plus the number of faulted attempts.
- R9: `startValid` is ignored while `busy` is high, and the running operation's results are unaffected.
- R10: While `memReqValid` is high and `memReqReady` is low, the request stays raised and `memReqAddr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start pulse, accepted only when idle |
| startMask | input | LANES | Lanes to gather |
| startBase | input | ADDR_W | Base address |
| startIdx | input | LANES*IDX_W | Per-lane unsigned index, lane i at [i*IDX_W +: IDX_W] |
| startData | input | LANES*DATA_W | Prior destination contents |
| irqPending | input | 1 | Asynchronous interrupt pending |
| memReqValid | output | 1 | Read request valid |
| memReqAddr | output | ADDR_W | Read address |
| memReqReady | input | 1 | Memory accepts request |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | DATA_W | Read data |
| memRspFault | input | 1 | Response carries a fault |
| busy | output | 1 | Operation in progress |
| doneValid | output | 1 | One-cycle end-of-operation pulse |
| doneStatus | output | 2 | 0 complete, 1 interrupted, 2 faulted |
| faultLane | output | $clog2(LANES) | Lane of the last fault |
| faultAddr | output | ADDR_W | Address of the last fault |
| maskOut | output | LANES | Remaining lanes |
| dataOut | output | LANES*DATA_W | Destination vector |

## Verification
The hardest case to reach is an interrupt or fault landing at a chosen element boundary, followed by a chain of restarts that must neither repeat nor skip a lane. The stimulus holds `irqPending` high for the whole run, which forces exactly one element per start. It also randomly pulses `irqPending` while the responder adds random ready and latency delays, and it arms a fault on a chosen lane's address that is cleared after the first hit. The bench drives restarts from `maskOut` and `dataOut` until the gather completes, then compares the request count and final vector with an independent computation.

// File: rtl/gather_pkg.sv
package gather_pkg;

  typedef enum logic [1:0] {
    END_DONE  = 2'd0,
    END_INTR  = 2'd1,
    END_FAULT = 2'd2
  } endStatus_e;

  typedef struct packed {
    logic loadStart;
    logic issue;
    logic commit;
    logic recordFault;
  } gatherStrobe_t;

endpackage

// File: rtl/gather_lane_pick.sv
module gather_lane_pick #(
  parameter int LANES  = 8,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]  mask,
  output logic              anySet,
  output logic [LANE_W-1:0] lane
);
  logic [LANES-1:0] lowerSeen;
  logic [LANES-1:0] firstHot;

  assign lowerSeen[0] = 1'b0;
  assign firstHot[0]  = mask[0];

  genvar g;
  generate
    for (g = 1; g < LANES; g++) begin : gen_chain
      assign lowerSeen[g] = lowerSeen[g-1] | mask[g-1];
      assign firstHot[g]  = mask[g] & ~lowerSeen[g];
    end
  endgenerate

  assign anySet = |mask;

  always_comb begin
    lane = '0;
    for (int i = 0; i < LANES; i++) begin
      if (firstHot[i]) lane = lane | LANE_W'(i);
    end
  end
endmodule

// File: rtl/gather_datapath.sv
module gather_datapath
  import gather_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 16,
  parameter int ELEM_BYTES = 4,
  parameter int LANE_W     = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  gatherStrobe_t           strobe,
  input  logic [LANES-1:0]        startMask,
  input  logic [ADDR_W-1:0]       startBase,
  input  logic [LANES*IDX_W-1:0]  startIdx,
  input  logic [LANES*DATA_W-1:0] startData,
  input  logic [DATA_W-1:0]       rspData,
  output logic                    maskZero,
  output logic [ADDR_W-1:0]       reqAddr,
  output logic [LANE_W-1:0]       faultLane,
  output logic [ADDR_W-1:0]       faultAddr,
  output logic [LANES-1:0]        maskOut,
  output logic [LANES*DATA_W-1:0] dataOut
);
  localparam logic [ADDR_W-1:0] ELEM_SZ = ADDR_W'(ELEM_BYTES);

  logic [LANES-1:0]  maskReg;
  logic [ADDR_W-1:0] baseReg;
  logic [IDX_W-1:0]  idxArr  [LANES];
  logic [DATA_W-1:0] dataArr [LANES];
  logic [LANE_W-1:0] curLane;
  logic [LANE_W-1:0] pickLane;
  logic              pickAny;

  gather_lane_pick #(.LANES(LANES), .LANE_W(LANE_W)) pick_i (
    .mask   (maskReg),
    .anySet (pickAny),
    .lane   (pickLane)
  );

  assign maskZero = ~pickAny;
  assign maskOut  = maskReg;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gen_lane
      always_ff @(posedge clk) begin
        if (!rstN) begin
          idxArr[g]  <= '0;
          dataArr[g] <= '0;
        end else if (strobe.loadStart) begin
          idxArr[g]  <= startIdx[g*IDX_W +: IDX_W];
          dataArr[g] <= startData[g*DATA_W +: DATA_W];
        end else if (strobe.commit && curLane == LANE_W'(g)) begin
          dataArr[g] <= rspData;
        end
      end
      assign dataOut[g*DATA_W +: DATA_W] = dataArr[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= '0;
      baseReg   <= '0;
      curLane   <= '0;
      reqAddr   <= '0;
      faultLane <= '0;
      faultAddr <= '0;
    end else begin
      if (strobe.loadStart) begin
        maskReg <= startMask;
        baseReg <= startBase;
      end
      if (strobe.issue) begin
        curLane <= pickLane;
        reqAddr <= baseReg + ADDR_W'(idxArr[pickLane]) * ELEM_SZ;
      end
      if (strobe.commit) begin
        maskReg[curLane] <= 1'b0;
      end
      if (strobe.recordFault) begin
        faultLane <= curLane;
        faultAddr <= reqAddr;
      end
    end
  end

  // R4
  commit_clears_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !maskReg[$past(curLane)]);

  // R8
  mask_only_shrinks_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadStart |=> (maskReg & ~$past(maskReg)) == '0);

  // R5
  fault_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.recordFault |=> maskReg == $past(maskReg));
endmodule

// File: rtl/gather_ctrl.sv
module gather_ctrl
  import gather_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startValid,
  input  logic          irqPending,
  input  logic          memReqReady,
  input  logic          memRspValid,
  input  logic          memRspFault,
  input  logic          maskZero,
  output gatherStrobe_t strobe,
  output logic          memReqValid,
  output logic          busy,
  output logic          doneValid,
  output logic [1:0]    doneStatus
);
  typedef enum logic [1:0] {S_IDLE, S_PICK, S_REQ, S_WAIT} ctrlState_e;

  ctrlState_e state;
  logic       firstElem;
  logic       irqStop;

  assign irqStop     = irqPending && !firstElem;
  assign memReqValid = (state == S_REQ);
  assign busy        = (state != S_IDLE);

  always_comb begin
    strobe             = '0;
    strobe.loadStart   = (state == S_IDLE) && startValid;
    strobe.issue       = (state == S_PICK) && !maskZero && !irqStop;
    strobe.commit      = (state == S_WAIT) && memRspValid && !memRspFault;
    strobe.recordFault = (state == S_WAIT) && memRspValid && memRspFault;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      firstElem  <= 1'b0;
      doneValid  <= 1'b0;
      doneStatus <= END_DONE;
    end else begin
      doneValid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (startValid) begin
            state     <= S_PICK;
            firstElem <= 1'b1;
          end
        end
        S_PICK: begin
          if (maskZero) begin
            state      <= S_IDLE;
            doneValid  <= 1'b1;
            doneStatus <= END_DONE;
          end else if (irqStop) begin
            state      <= S_IDLE;
            doneValid  <= 1'b1;
            doneStatus <= END_INTR;
          end else begin
            state     <= S_REQ;
            firstElem <= 1'b0;
          end
        end
        S_REQ: begin
          if (memReqReady) state <= S_WAIT;
        end
        S_WAIT: begin
          if (memRspValid) begin
            if (memRspFault) begin
              state      <= S_IDLE;
              doneValid  <= 1'b1;
              doneStatus <= END_FAULT;
            end else begin
              state <= S_PICK;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);

  // R6
  intr_needs_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus == END_INTR) |-> $past(irqPending));

  // R7
  done_needs_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus == END_DONE) |-> maskZero);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startValid) |-> !strobe.loadStart);
endmodule

// File: rtl/gather_engine.sv
module gather_engine
  import gather_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 16,
  parameter int ELEM_BYTES = 4,
  localparam int LANE_W    = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startValid,
  input  logic [LANES-1:0]        startMask,
  input  logic [ADDR_W-1:0]       startBase,
  input  logic [LANES*IDX_W-1:0]  startIdx,
  input  logic [LANES*DATA_W-1:0] startData,
  input  logic                    irqPending,
  output logic                    memReqValid,
  output logic [ADDR_W-1:0]       memReqAddr,
  input  logic                    memReqReady,
  input  logic                    memRspValid,
  input  logic [DATA_W-1:0]       memRspData,
  input  logic                    memRspFault,
  output logic                    busy,
  output logic                    doneValid,
  output logic [1:0]              doneStatus,
  output logic [LANE_W-1:0]       faultLane,
  output logic [ADDR_W-1:0]       faultAddr,
  output logic [LANES-1:0]        maskOut,
  output logic [LANES*DATA_W-1:0] dataOut
);
  gatherStrobe_t strobe;
  logic          maskZero;

  gather_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startValid  (startValid),
    .irqPending  (irqPending),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memRspFault (memRspFault),
    .maskZero    (maskZero),
    .strobe      (strobe),
    .memReqValid (memReqValid),
    .busy        (busy),
    .doneValid   (doneValid),
    .doneStatus  (doneStatus)
  );

  gather_datapath #(
    .LANES(LANES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .IDX_W(IDX_W), .ELEM_BYTES(ELEM_BYTES), .LANE_W(LANE_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startMask (startMask),
    .startBase (startBase),
    .startIdx  (startIdx),
    .startData (startData),
    .rspData   (memRspData),
    .maskZero  (maskZero),
    .reqAddr   (memReqAddr),
    .faultLane (faultLane),
    .faultAddr (faultAddr),
    .maskOut   (maskOut),
    .dataOut   (dataOut)
  );

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));
endmodule

// File: tb/gather_engine_tb.sv
module gather_engine_tb_top;
  localparam int LANES = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int IDX_W = 16;
  localparam int ELEM = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [LANES-1:0] startMask = '0;
  logic [ADDR_W-1:0] startBase = '0;
  logic [LANES*IDX_W-1:0] startIdx = '0;
  logic [LANES*DATA_W-1:0] startData = '0;
  logic irqPending = 1'b0;
  logic memReqValid;
  logic [ADDR_W-1:0] memReqAddr;
  logic memReqReady = 1'b0;
  logic memRspValid = 1'b0;
  logic [DATA_W-1:0] memRspData = '0;
  logic memRspFault = 1'b0;
  logic busy, doneValid;
  logic [1:0] doneStatus;
  logic [2:0] faultLane;
  logic [ADDR_W-1:0] faultAddr;
  logic [LANES-1:0] maskOut;
  logic [LANES*DATA_W-1:0] dataOut;

  always #2 clk = ~clk;

  gather_engine dut_i (.*);

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model state
  logic [ADDR_W-1:0] curBase;
  logic [IDX_W-1:0]  curIdx [LANES];
  logic [LANES-1:0]  modelMask;
  logic [DATA_W-1:0] modelData [LANES];
  bit   faultArmed = 0;
  logic [ADDR_W-1:0] faultSel;
  bit   sawFault;
  int   faultLaneSeen;
  logic [ADDR_W-1:0] faultAddrSeen;
  int   reqCount = 0;

  function automatic logic [DATA_W-1:0] memData(input logic [ADDR_W-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  function automatic logic [ADDR_W-1:0] laneAddr(input logic [ADDR_W-1:0] b,
                                                 input logic [IDX_W-1:0] ix);
    return b + ADDR_W'(ix) * ADDR_W'(ELEM);
  endfunction

  function automatic int lowestLane(input logic [LANES-1:0] m);
    for (int i = 0; i < LANES; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // memory responder with random ready and latency
  initial begin : responder
    bit pending = 0;
    int waitCnt = 0;
    int pLane = 0;
    logic [ADDR_W-1:0] pAddr = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      memRspFault = 1'b0;
      memReqReady = 1'b0;
      if (!rstN) begin
        pending = 0;
      end else if (pending) begin
        if (memReqValid) check(0, "R3 request while one outstanding", 1, 0);
        if (waitCnt == 0) begin
          pending = 0;
          memRspValid = 1'b1;
          if (faultArmed && pAddr == faultSel) begin
            memRspFault = 1'b1;
            sawFault = 1;
            faultLaneSeen = pLane;
            faultAddrSeen = pAddr;
          end else begin
            memRspData = memData(pAddr);
            modelData[pLane] = memData(pAddr);
            modelMask[pLane] = 1'b0;
          end
        end else begin
          waitCnt--;
        end
      end else if (memReqValid && ($urandom % 3 != 0)) begin
        pLane = lowestLane(modelMask);
        pAddr = memReqAddr;
        check(pLane >= 0 && memReqAddr == laneAddr(curBase, curIdx[pLane]),
              "R2 address/order", memReqAddr,
              (pLane >= 0) ? laneAddr(curBase, curIdx[pLane]) : 0);
        if (pLane < 0) pLane = 0;
        memReqReady = 1'b1;
        pending = 1;
        waitCnt = $urandom % 3;
        reqCount++;
      end
    end
  end

  // one start; returns the status seen
  task automatic runOp(input logic [LANES-1:0] m, input int irqMode, input bit pokeStart,
                       output int status);
    int startReqs;
    int cyc;
    bit poked;
    for (int i = 0; i < LANES; i++) begin
      startIdx[i*IDX_W +: IDX_W] = curIdx[i];
      startData[i*DATA_W +: DATA_W] = modelData[i];
    end
    startMask = m;
    startBase = curBase;
    modelMask = m;
    sawFault = 0;
    startReqs = reqCount;
    irqPending = (irqMode == 1);
    @(negedge clk);
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    cyc = 0;
    poked = 0;
    while (!doneValid && cyc < 3000) begin
      if (irqMode == 2) irqPending = ($urandom % 4 == 0);
      if (pokeStart && !poked && busy) begin
        startValid = 1'b1;
        startMask = ~m;
        startBase = curBase + 32'h100;
        poked = 1;
      end else begin
        startValid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    startValid = 1'b0;
    irqPending = 1'b0;
    status = doneStatus;
    check(doneValid, "R7 operation ended", doneValid, 1);
    if (sawFault) begin
      check(doneStatus == 2, "R5 fault status", doneStatus, 2);
      check(faultLane == faultLaneSeen[2:0], "R5 fault lane", faultLane, faultLaneSeen);
      check(faultAddr == faultAddrSeen, "R5 fault address", faultAddr, faultAddrSeen);
      check(maskOut[faultLaneSeen], "R5 faulting lane stays set", maskOut, modelMask);
    end else if (modelMask == '0) begin
      check(doneStatus == 0, "R7 complete status", doneStatus, 0);
    end else begin
      check(doneStatus == 1 && irqMode != 0, "R6 interrupted status", doneStatus, 1);
    end
    if (irqMode == 1 && m != '0)
      check(reqCount - startReqs == 1, "R6 one element per start under irq",
            reqCount - startReqs, 1);
    check(maskOut == modelMask, "R4 mask out", maskOut, modelMask);
    for (int i = 0; i < LANES; i++)
      check(dataOut[i*DATA_W +: DATA_W] == modelData[i], "R4 lane data",
            dataOut[i*DATA_W +: DATA_W], modelData[i]);
  endtask

  // full gather with restarts
  task automatic doGather(input logic [LANES-1:0] m, input int irqMode,
                          input int faultLaneSel, input bit pokeStart);
    logic [DATA_W-1:0] initData [LANES];
    logic [LANES-1:0] cur;
    int st;
    int faults;
    int reqStart;
    int iter;
    for (int i = 0; i < LANES; i++) begin
      initData[i] = $urandom;
      modelData[i] = initData[i];
    end
    faultArmed = (faultLaneSel >= 0);
    if (faultArmed) faultSel = laneAddr(curBase, curIdx[faultLaneSel]);
    faults = 0;
    reqStart = reqCount;
    cur = m;
    iter = 0;
    st = 1;
    while (iter < 40) begin
      runOp(cur, irqMode, pokeStart && iter == 0, st);
      cur = maskOut;
      iter++;
      if (st == 2) begin
        faults++;
        faultArmed = 0;
      end else if (st == 0) begin
        break;
      end
    end
    check(st == 0, "R8 gather eventually completes", st, 0);
    check(reqCount - reqStart == $countones(m) + faults, "R8 no lane redone",
          reqCount - reqStart, $countones(m) + faults);
    for (int i = 0; i < LANES; i++) begin
      logic [DATA_W-1:0] e;
      e = m[i] ? memData(laneAddr(curBase, curIdx[i])) : initData[i];
      check(dataOut[i*DATA_W +: DATA_W] == e, "R8 final vector",
            dataOut[i*DATA_W +: DATA_W], e);
    end
    faultArmed = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishUp();
  end

  initial begin : main
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    check(!busy && !doneValid && !memReqValid, "R1 during reset",
          {busy, doneValid, memReqValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !doneValid && !memReqValid, "R1 after reset",
          {busy, doneValid, memReqValid}, 0);

    // directed: zero mask completes with no read
    curBase = 32'h1000;
    for (int i = 0; i < LANES; i++) curIdx[i] = IDX_W'(i * 3);
    begin
      int r0;
      int st;
      r0 = reqCount;
      doGather('0, 1, -1, 0);
      check(reqCount == r0, "R7 zero mask makes no read", reqCount - r0, 0);
      runOp('0, 0, 0, st);
      check(st == 0, "R7 zero mask status", st, 0);
    end

    // directed: irq held, full mask -> one element per start
    doGather(8'hFF, 1, -1, 0);
    // directed: single lane with irq held -> completes (R7 priority)
    begin
      int st;
      for (int i = 0; i < LANES; i++) modelData[i] = '0;
      runOp(8'h10, 1, 0, st);
      check(st == 0, "R7 empty mask beats irq", st, 0);
    end
    // directed: faults on first and last lane, descending indices
    for (int i = 0; i < LANES; i++) curIdx[i] = IDX_W'(100 - i * 7);
    doGather(8'hA5, 0, 0, 0);
    doGather(8'hA5, 0, 7, 0);
    // directed: start poked while busy
    doGather(8'h3C, 0, -1, 1);
    // directed: large index wraps into high address bits
    curBase = 32'hFFFF_FF00;
    for (int i = 0; i < LANES; i++) curIdx[i] = IDX_W'(16'hFFF0 + i);
    doGather(8'h81, 2, -1, 0);

    // random
    for (int t = 0; t < 40; t++) begin
      logic [LANES-1:0] m;
      int fl;
      curBase = {$urandom} & 32'hFFFF_FFFC;
      for (int i = 0; i < LANES; i++) curIdx[i] = IDX_W'($urandom % 64);
      m = LANES'($urandom);
      fl = -1;
      if (m != '0 && ($urandom % 2 == 0)) begin
        fl = $urandom % LANES;
        while (!m[fl]) fl = (fl + 1) % LANES;
      end
      doGather(m, $urandom % 3, fl, ($urandom % 4 == 0));
    end

    finishUp();
  end
endmodule